// File: doc/BRIEF.md
# Flow-through SEC-DED memory EDAC

This block sits in the data path between a processor and a 16-bit memory. On the write side it computes a check word for the outgoing data word, and the memory stores it next to the data. On the read side it recomputes the check word over the returned data and XORs it with the stored check bits. The result is a syndrome. From the syndrome the block corrects any single-bit error and detects every double-bit error.

The check word width can be selected. In wide mode all eight check bits are stored and used, which gives 24 stored bits. In narrow mode only check bits 0 to 5 are stored, which gives 22 stored bits; the upper two syndrome bits are then forced to zero and stored bits 7:6 are ignored. A mode input selects one of two behaviours. In correct mode a single-bit data error is repaired in the read data. In detect mode the read data passes through untouched and errors are only flagged. The raw syndrome is brought out so that software can analyse it.

The write path and the read path are independent and both work in every cycle. All outputs are registered, so every output reflects the inputs sampled on the previous rising clock edge.

Top module: `edac16_ft`

## Requirements
- R1: One cycle after `wr_data_i` is sampled, `wr_check_o[k]` equals the parity of `wr_data_i & M[k]`, inverted for k = 2, 3 and 7. The masks are M[0]=16'h31F1, M[1]=16'h8AEF, M[2]=16'h5F32, M[3]=16'h641F, M[4]=16'hA744, M[5]=16'hD888, M[6]=M[7]=16'hFF00. All 8 bits are produced in both width modes, and the read inputs have no effect on them.
- R2: One cycle after sampling, `syndrome_o` equals the R1 check word of `rd_data_i` XOR `rd_check_i`, with bits 7:6 cleared in narrow mode.
- R3: A zero syndrome gives `ce_o`=0, `ue_o`=0 and `rd_data_o` equal to the sampled `rd_data_i`.
- R4: In correct mode (`correct_en_i`=1), a single flipped data bit is restored in `rd_data_o`, with `ce_o`=1 and `ue_o`=0.
- R5: A single flipped stored check bit within the active width gives `ce_o`=1 and `ue_o`=0, and `rd_data_o` is unchanged.
- R6: Any two flipped bits (data or active check bits) give `ue_o`=1 and `ce_o`=0, and `rd_data_o` equals the sampled `rd_data_i`, in either mode.
- R7: In detect mode (`correct_en_i`=0), `rd_data_o` always equals the sampled `rd_data_i`, while a single error still raises `ce_o`.
- R8: In narrow mode (`wide_check_i`=0), `rd_check_i[7:6]` has no effect on any output, and `syndrome_o[7:6]` is 0.
- R9: After reset all outputs are 0. Every output has exactly one cycle of latency, and a new word is accepted every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_data_i | input | 16 | Data word to be written to memory |
| rd_data_i | input | 16 | Data word read from memory |
| rd_check_i | input | 8 | Check bits read from memory |
| correct_en_i | input | 1 | 1 = correct single errors, 0 = detect only |
| wide_check_i | input | 1 | 1 = 8 check bits, 0 = 6 check bits |
| wr_check_o | output | 8 | Check word for the written data |
| rd_data_o | output | 16 | Read data, corrected when enabled |
| syndrome_o | output | 8 | Raw syndrome of the read word |
| ce_o | output | 1 | Single (correctable) error seen |
| ue_o | output | 1 | Uncorrectable error seen |

## Verification
Encoding for a write and decoding of a read fall in the same cycle, because the two paths share the clock and the register stage. The bench drives an unrelated write word alongside every read word, including reads that carry injected single and double faults. In the same cycle it judges the check word against its own encoder and the read results against the faults it injected. A crossed path therefore shows up as a wrong check word or a wrong flag.

// File: rtl/edac16_pkg.sv
package edac16_pkg;
  localparam int DW = 16;
  localparam int CW = 8;
  localparam int NARROW_CW = 6;

  typedef logic [DW-1:0] data_t;
  typedef logic [CW-1:0] chk_t;

  // row k: data bits folded into check bit k
  localparam logic [CW-1:0][DW-1:0] ROWS = {
    16'hFF00, 16'hFF00, 16'hD888, 16'hA744,
    16'h641F, 16'h5F32, 16'h8AEF, 16'h31F1
  };
  // check bits using odd parity
  localparam chk_t ODD_MASK = 8'h8C;

  function automatic chk_t active_mask(input logic wide);
    chk_t m;
    for (int k = 0; k < CW; k++) m[k] = wide || (k < NARROW_CW);
    return m;
  endfunction
endpackage

// File: rtl/edac16_chk_gen.sv
module edac16_chk_gen
  import edac16_pkg::*;
(
  input  data_t data_i,
  output chk_t  check_o
);
  for (genvar k = 0; k < CW; k++) begin : g_bit
    assign check_o[k] = (^(data_i & ROWS[k])) ^ ODD_MASK[k];
  end
endmodule

// File: rtl/edac16_syn_dec.sv
module edac16_syn_dec
  import edac16_pkg::*;
(
  input  chk_t  syn_i,
  input  logic  wide_i,
  output data_t hit_o,
  output logic  single_o,
  output logic  multi_o
);
  chk_t act;
  logic chk_hit;

  assign act = active_mask(wide_i);

  for (genvar j = 0; j < DW; j++) begin : g_col
    chk_t col;
    for (genvar k = 0; k < CW; k++) begin : g_row
      assign col[k] = ROWS[k][j] & act[k];
    end
    assign hit_o[j] = (syn_i == col);
  end

  assign chk_hit  = $onehot(syn_i);
  assign single_o = (|hit_o) | chk_hit;
  assign multi_o  = (syn_i != '0) && !single_o;
endmodule

// File: rtl/edac16_fix.sv
module edac16_fix
  import edac16_pkg::*;
(
  input  data_t data_i,
  input  data_t hit_i,
  input  logic  correct_en_i,
  output data_t data_o
);
  assign data_o = data_i ^ (hit_i & {DW{correct_en_i}});
endmodule

// File: rtl/edac16_ft.sv
module edac16_ft
  import edac16_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [15:0] wr_data_i,
  input  logic [15:0] rd_data_i,
  input  logic [7:0]  rd_check_i,
  input  logic        correct_en_i,
  input  logic        wide_check_i,
  output logic [7:0]  wr_check_o,
  output logic [15:0] rd_data_o,
  output logic [7:0]  syndrome_o,
  output logic        ce_o,
  output logic        ue_o
);
  chk_t  wr_chk, rd_regen, syn;
  data_t hit, fixed;
  logic  single, multi;
  logic  primed_q;

  edac16_chk_gen u_wr_gen (.data_i(wr_data_i), .check_o(wr_chk));
  edac16_chk_gen u_rd_gen (.data_i(rd_data_i), .check_o(rd_regen));

  assign syn = (rd_regen ^ rd_check_i) & active_mask(wide_check_i);

  edac16_syn_dec u_dec (
    .syn_i(syn), .wide_i(wide_check_i),
    .hit_o(hit), .single_o(single), .multi_o(multi)
  );

  edac16_fix u_fix (
    .data_i(rd_data_i), .hit_i(hit),
    .correct_en_i(correct_en_i), .data_o(fixed)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_check_o <= '0;
      rd_data_o  <= '0;
      syndrome_o <= '0;
      ce_o       <= 1'b0;
      ue_o       <= 1'b0;
      primed_q   <= 1'b0;
    end else begin
      wr_check_o <= wr_chk;
      rd_data_o  <= fixed;
      syndrome_o <= syn;
      ce_o       <= single;
      ue_o       <= multi;
      primed_q   <= 1'b1;
    end
  end

  a_r6_flags_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ce_o && ue_o));
  a_r3_clean_no_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (syndrome_o == '0) |-> (!ce_o && !ue_o));
  a_r4_at_most_one_flip: assert property (@(posedge clk_i) disable iff (!rst_ni)
    primed_q |=> ($countones(rd_data_o ^ $past(rd_data_i)) <= 1));
  a_r6_ue_passthru: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (primed_q && multi) |=> (ue_o && rd_data_o == $past(rd_data_i)));
  a_r7_detect_passthru: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (primed_q && !correct_en_i) |=> (rd_data_o == $past(rd_data_i)));
  a_r8_narrow_syn_top: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (primed_q && !wide_check_i) |=> (syndrome_o[7:6] == 2'b00));
endmodule

// File: tb/sim_edac16_ft.sv
module sim_edac16_ft;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] wr_data = '0, rd_data = '0;
  logic [7:0]  rd_check = '0;
  logic        corr = 1'b1, wide = 1'b1;
  logic [7:0]  wr_check, syndrome;
  logic [15:0] rd_out;
  logic        ce, ue;

  int checks = 0, errors = 0;
  bit active = 0, done = 0;

  typedef struct {
    logic [7:0]  chk;
    logic [15:0] data;
    logic [7:0]  syn;
    logic        ce, ue;
    string       tag;
  } exp_t;
  exp_t sbq[$];

  always #4 clk = ~clk;

  edac16_ft u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_data_i(wr_data), .rd_data_i(rd_data),
    .rd_check_i(rd_check), .correct_en_i(corr), .wide_check_i(wide),
    .wr_check_o(wr_check), .rd_data_o(rd_out), .syndrome_o(syndrome),
    .ce_o(ce), .ue_o(ue)
  );

  function automatic logic [7:0] enc(input logic [15:0] d);
    logic [15:0] m [8] = '{16'h31F1, 16'h8AEF, 16'h5F32, 16'h641F,
                           16'hA744, 16'hD888, 16'hFF00, 16'hFF00};
    logic [7:0] c;
    for (int k = 0; k < 8; k++) c[k] = ^(d & m[k]);
    return c ^ 8'h8C;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  // driver: clean word base, fault masks, optional junk on narrow-mode upper check bits
  task automatic send(input string tag, input logic [15:0] wd, input logic [15:0] base,
                      input logic [15:0] dflip, input logic [7:0] cflip,
                      input logic c_en, input logic w_en, input logic [1:0] junk);
    exp_t e;
    logic [7:0] act_m, rc, s;
    int n;
    @(negedge clk);
    act_m = w_en ? 8'hFF : 8'h3F;
    rc = enc(base) ^ cflip;
    if (!w_en) rc[7:6] = junk;
    wr_data = wd; rd_data = base ^ dflip; rd_check = rc; corr = c_en; wide = w_en;
    n = $countones(dflip) + $countones(cflip & act_m);
    s = (enc(base ^ dflip) ^ rc) & act_m;
    e.chk = enc(wd);
    e.syn = s;
    e.ce = (n == 1);
    e.ue = (n >= 2);
    e.data = (n == 1 && dflip != 0 && c_en) ? base : (base ^ dflip);
    e.tag = tag;
    sbq.push_back(e);
  endtask

  // monitor
  always @(posedge clk) begin
    if (active && sbq.size() > 0) begin
      exp_t e;
      e = sbq.pop_front();
      #1;
      check({"R1 ", e.tag}, {24'h0, wr_check}, {24'h0, e.chk});
      check({"R2 ", e.tag}, {24'h0, syndrome}, {24'h0, e.syn});
      check(e.tag, {16'h0, rd_out}, {16'h0, e.data});
      check({e.tag, " flags"}, {30'h0, ce, ue}, {30'h0, e.ce, e.ue});
    end
  end

  initial begin
    #100000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] lf;
    wr_data = 16'hA5A5; rd_data = 16'h5A5A; rd_check = 8'hFF;
    repeat (3) @(negedge clk);
    check("R9 reset outputs", {wr_check, rd_out, syndrome}, 32'h0);
    check("R9 reset flags", {30'h0, ce, ue}, 32'h0);
    rst_n = 1'b1;
    active = 1;
    // R3 clean words, both widths, write path busy at the same time
    send("R3 clean", 16'h0000, 16'h0000, 0, 0, 1, 1, 0);
    send("R3 clean", 16'hFFFF, 16'hFFFF, 0, 0, 1, 1, 0);
    send("R3 clean", 16'h1234, 16'hBEEF, 0, 0, 1, 0, 0);
    // R4 every data bit, wide and narrow
    for (int j = 0; j < 16; j++) send("R4 single data", 16'h0001 << j, 16'hC3A5 ^ j[15:0], 16'h1 << j, 0, 1, 1, 0);
    for (int j = 0; j < 16; j++) send("R4 single data narrow", ~(16'h1 << j), 16'h6E91, 16'h1 << j, 0, 1, 0, 2'b10);
    // R5 every active check bit
    for (int k = 0; k < 8; k++) send("R5 single check", 16'h00F0, 16'h7310, 0, 8'h1 << k, 1, 1, 0);
    for (int k = 0; k < 6; k++) send("R5 single check narrow", 16'h0F00, 16'h0C0C, 0, 8'h1 << k, 1, 0, 0);
    // R6 double faults
    for (int j = 0; j < 15; j++) send("R6 double data", 16'hAAAA, 16'h9D2B, 16'h3 << j, 0, 1, 1, 0);
    for (int j = 0; j < 15; j++) send("R6 double data narrow", 16'h5555, 16'h9D2B, 16'h3 << j, 0, 1, 0, 2'b01);
    for (int k = 0; k < 8; k++) send("R6 data+check", 16'h0F0F, 16'h4411, 16'h0100, 8'h1 << k, 1, 1, 0);
    send("R6 double check", 16'h1111, 16'h2222, 0, 8'h81, 1, 1, 0);
    send("R6 double detect", 16'h1111, 16'h2222, 16'h8001, 0, 0, 1, 0);
    // R7 detect mode
    for (int j = 0; j < 16; j += 3) send("R7 detect single", 16'hF00F, 16'h3C3C, 16'h1 << j, 0, 0, 1, 0);
    send("R7 detect clean", 16'hF00F, 16'h3C3C, 0, 0, 0, 0, 2'b11);
    // R8 upper stored check bits ignored in narrow mode
    for (int v = 0; v < 4; v++) send("R8 junk upper", 16'h8421, 16'h1248, 0, 0, 1, 0, v[1:0]);
    send("R8 junk with single", 16'h8421, 16'h1248, 16'h0040, 0, 1, 0, 2'b11);
    // R9 back-to-back pseudo-random mix
    lf = 16'hACE1;
    for (int i = 0; i < 200; i++) begin
      logic [15:0] df;
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      df = (i % 3 == 0) ? 16'h0 : (i % 3 == 1) ? (16'h1 << lf[3:0]) : (16'h1 << lf[3:0]) ^ (16'h1 << ((lf[3:0] + 4'd5) & 4'hF));
      send("R9 stream", ~lf, lf ^ 16'h5A3C, df, 0, lf[6], lf[7], lf[9:8]);
    end
    @(negedge clk); @(negedge clk);
    active = 0;
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule